// File: doc/BRIEF.md
# USB Clock and Reset Bring-Up Sequencer

This block powers up the clocking and PHY infrastructure that a high-speed and a full/low-speed USB host controller share. Either controller's driver path raises a one-cycle start request when it needs the infrastructure and a one-cycle stop request when it is done. An internal use count makes sure the bring-up runs only once for the first user, and the interface clock stays on until the last user has left.

Each bring-up step is a fixed state with its own control output pattern. The waits between steps are counted in I/O clock cycles. Every wait is a parameter whose default comes from the I/O clock frequency, rounded up and never less than one cycle. The host-clock divider select is worked out at elaboration from the I/O clock rate. After both resets are released, the block writes a transmitter reference tune value to each PHY port in turn and then reports ready.

Top module: `usbclk_seq`

## Requirements
- R1: After reset, every output is 0. This includes the interface clock enable, every reset and enable control, the divider select, the test-reset, the tune write fields, busy and ready.
- R2: A start request that takes the use count from 0 to 1 has this effect from the next cycle onward, one cycle per step. The interface clock enable rises first. Next the PHY power-on reset (active high) is asserted while the host reset, the port reset and both divider resets (active low) stay at 0. Then the host divider select is loaded, then the host divider enable is set, and then the host divider reset control is released to 1.
- R3: The power-on reset stays high for DIVRST_WAIT_CYC cycles after the host divider reset is released. It then drops, and the block waits PHYCLK_WAIT_CYC cycles for the PHY clock.
- R4: The PHY test-reset is then high for exactly TEST_HOLD_CYC cycles and low for TEST_GAP_CYC cycles before the next step.
- R5: The full-speed divider reset control is released for one cycle before its enable is set. DIVRST_WAIT_CYC cycles later the port reset control is released. PORT_WAIT_CYC cycles after that the host reset control is released.
- R6: In the cycle after the host reset is released, the block writes TUNE_VAL (15) to port 0. It writes to port 1 in the next cycle, and ready is high in the cycle after that. tune_val is 0 whenever no write is made.
- R7: With q = floor(IO_CLK_HZ / 130,000,000), the divider select is 1 for q=0, q for q=1..4, 4 for q=5, 6 for q=6..7, 8 for q=8..11 and 12 for q≥12.
- R8: The default wait counts are ceil(IO_CLK_HZ·t / 1e9) cycles with a minimum of 1, for t = 1 ms, 10 ns, 20 ns and 1 µs. The divider wait is 64 cycles.
- R9: A start request made while the count is nonzero only increments the count. It does not restart or change a running or finished sequence.
- R10: A stop request decrements the count. While the count stays above 0 the outputs do not change. When it reaches 0, every output returns to its reset value in the next cycle.
- R11: A stop that brings the count to 0 while busy aborts the sequence, with all outputs at their reset values in the next cycle. A later start from 0 runs the sequence again from its first step.
- R12: A stop request when the count is already 0 is ignored. The count does not wrap, so a single later start followed by a single stop clears the outputs again.
- R13: Busy is high from the interface clock enable step through the last tune write and low otherwise. Ready is high only after the last tune write, until the count returns to 0, and it is never high together with busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | One-cycle request to use the infrastructure |
| stop_req | input | 1 | One-cycle release of one use |
| if_clk_en | output | 1 | Interface clock enable |
| phy_por | output | 1 | PHY power-on reset, active high |
| phy_port_rst_n | output | 1 | PHY port reset control, 0 holds reset |
| host_rst_n | output | 1 | Host controller reset control, 0 holds reset |
| hdiv_en | output | 1 | Host-clock divider enable |
| hdiv_rst_n | output | 1 | Host-clock divider reset control, 0 holds reset |
| fsdiv_en | output | 1 | Full-speed clock divider enable |
| fsdiv_rst_n | output | 1 | Full-speed divider reset control, 0 holds reset |
| hdiv_sel | output | 4 | Host-clock divide value |
| phy_test_rst | output | 1 | PHY test-reset pulse |
| tune_we | output | 1 | Per-port tune write strobe |
| tune_port | output | PORT_W | Port addressed by the tune write |
| tune_val | output | 4 | Transmitter reference tune value being written |
| busy | output | 1 | Bring-up sequence in progress |
| ready | output | 1 | Infrastructure up and usable |

## Verification
A request sampled at a clock edge shows its effect on the outputs right after that edge. The bench drives each pulse on a falling edge and reads the outputs on the next falling edge, so that reading is step 0 of the sequence. From there it checks every cycle of the whole bring-up against a step table, and each step lasts as long as the requirements set. Stops that reach zero are checked one sample after the pulse. For the rounding and quotient-map cases, the bench computes the exact cycle at which ready must rise and checks both that cycle and the one before it.

// File: rtl/usbclk_pkg.sv
package usbclk_pkg;

   localparam int unsigned HDIV_W = 4;
   localparam longint unsigned NS_PER_S = 64'd1_000_000_000;
   localparam longint unsigned HDIV_STEP_HZ = 64'd130_000_000;

   // Steps are ordered: output decode relies on comparisons of this order.
   typedef enum logic [4:0] {
      S_IDLE,
      S_IFEN,
      S_RSTALL,
      S_HDIV_LD,
      S_HDIV_EN,
      S_HDIV_REL,
      S_POR_HOLD,
      S_PHYCLK_WAIT,
      S_TEST_PULSE,
      S_TEST_GAP,
      S_FSDIV_REL,
      S_FSDIV_EN,
      S_PORT_REL,
      S_HOST_REL,
      S_TUNE,
      S_READY
   } seq_st_t;

   // Wait length in cycles, rounded up, never below one cycle.
   function automatic int unsigned ns_to_cyc(input longint unsigned hz,
                                             input longint unsigned ns);
      longint unsigned c;
      c = (hz * ns + NS_PER_S - 64'd1) / NS_PER_S;
      if (c == 64'd0) c = 64'd1;
      return c[31:0];
   endfunction

   // Non-linear quotient map for the host-clock divider.
   function automatic logic [HDIV_W-1:0] hdiv_pick(input longint unsigned hz);
      longint unsigned q;
      q = hz / HDIV_STEP_HZ;
      if (q == 64'd0)       return 4'd1;
      else if (q <= 64'd4)  return q[HDIV_W-1:0];
      else if (q == 64'd5)  return 4'd4;
      else if (q <= 64'd7)  return 4'd6;
      else if (q <= 64'd11) return 4'd8;
      else                  return 4'd12;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/usbclk_usecnt.sv
module usbclk_usecnt #(
   parameter int unsigned USE_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic stop_req,
   output logic launch,
   output logic drop
);

   generate
      if (USE_W < 1) begin : g_bad_w
         $error("usbclk_usecnt: USE_W must be at least 1");
      end
   endgenerate

   logic [USE_W-1:0] cnt_q;
   logic             inc;
   logic             dec;

   // A start and a stop in the same cycle cancel out.
   assign inc    = start_req & ~stop_req;
   assign dec    = stop_req & ~start_req & (cnt_q != '0);
   assign launch = inc & (cnt_q == '0);
   assign drop   = dec & (cnt_q == USE_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + USE_W'(1);
      else if (dec) cnt_q <= cnt_q - USE_W'(1);
   end

   AST_USE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> (cnt_q != '1));                                            // R9
   AST_USE_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !start_req && cnt_q == '0) |=> (cnt_q == '0));        // R12

endmodule

// File: rtl/usbclk_waittimer.sv
module usbclk_waittimer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("usbclk_waittimer: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign expired = (cnt_q == limit - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (restart)  cnt_q <= '0;
      else if (!expired) cnt_q <= cnt_q + CNT_W'(1);
   end

   AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (limit != '0) |-> (cnt_q < limit));                                // R3

endmodule

// File: rtl/usbclk_seq.sv
module usbclk_seq
   import usbclk_pkg::*;
#(
   parameter longint unsigned IO_CLK_HZ     = 64'd1_000_000_000,
   parameter int unsigned USE_W             = 4,
   parameter int unsigned N_PORTS           = 2,
   parameter logic [3:0]  TUNE_VAL          = 4'd15,
   parameter int unsigned DIVRST_WAIT_CYC   = 64,
   parameter int unsigned PHYCLK_WAIT_CYC   = ns_to_cyc(IO_CLK_HZ, 64'd1_000_000),
   parameter int unsigned TEST_HOLD_CYC     = ns_to_cyc(IO_CLK_HZ, 64'd10),
   parameter int unsigned TEST_GAP_CYC      = ns_to_cyc(IO_CLK_HZ, 64'd20),
   parameter int unsigned PORT_WAIT_CYC     = ns_to_cyc(IO_CLK_HZ, 64'd1_000),
   localparam int unsigned PORT_W           = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic              stop_req,
   output logic              if_clk_en,
   output logic              phy_por,
   output logic              phy_port_rst_n,
   output logic              host_rst_n,
   output logic              hdiv_en,
   output logic              hdiv_rst_n,
   output logic              fsdiv_en,
   output logic              fsdiv_rst_n,
   output logic [HDIV_W-1:0] hdiv_sel,
   output logic              phy_test_rst,
   output logic              tune_we,
   output logic [PORT_W-1:0] tune_port,
   output logic [3:0]        tune_val,
   output logic              busy,
   output logic              ready
);

   localparam logic [HDIV_W-1:0] HDIV_VAL = hdiv_pick(IO_CLK_HZ);
   localparam int unsigned MAX_WAIT =
      max2(max2(max2(DIVRST_WAIT_CYC, PHYCLK_WAIT_CYC), max2(TEST_HOLD_CYC, TEST_GAP_CYC)),
           PORT_WAIT_CYC);
   localparam int unsigned CNT_W = $clog2(MAX_WAIT + 1);

   generate
      if (IO_CLK_HZ == 64'd0) begin : g_bad_hz
         $error("usbclk_seq: IO_CLK_HZ must be nonzero");
      end
      if (N_PORTS < 1) begin : g_bad_ports
         $error("usbclk_seq: N_PORTS must be at least 1");
      end
      if (DIVRST_WAIT_CYC < 1 || PHYCLK_WAIT_CYC < 1 || TEST_HOLD_CYC < 1 ||
          TEST_GAP_CYC < 1 || PORT_WAIT_CYC < 1) begin : g_bad_wait
         $error("usbclk_seq: every wait must be at least one cycle");
      end
   endgenerate

   seq_st_t          st_q, st_d;
   logic             launch, drop;
   logic             expired, restart;
   logic [CNT_W-1:0] wait_lim;
   logic             tune_last;
   logic [PORT_W-1:0] tune_idx;

   usbclk_usecnt #(.USE_W(USE_W)) u_use (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .stop_req  (stop_req),
      .launch    (launch),
      .drop      (drop)
   );

   // One shared counter times whichever wait the current step needs.
   always_comb begin
      unique case (st_q)
         S_POR_HOLD:    wait_lim = CNT_W'(DIVRST_WAIT_CYC);
         S_PHYCLK_WAIT: wait_lim = CNT_W'(PHYCLK_WAIT_CYC);
         S_TEST_PULSE:  wait_lim = CNT_W'(TEST_HOLD_CYC);
         S_TEST_GAP:    wait_lim = CNT_W'(TEST_GAP_CYC);
         S_FSDIV_EN:    wait_lim = CNT_W'(DIVRST_WAIT_CYC);
         S_PORT_REL:    wait_lim = CNT_W'(PORT_WAIT_CYC);
         default:       wait_lim = CNT_W'(1);
      endcase
   end

   usbclk_waittimer #(.CNT_W(CNT_W)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .limit   (wait_lim),
      .expired (expired)
   );

   always_comb begin
      st_d = st_q;
      if (drop) begin
         st_d = S_IDLE;
      end else begin
         unique case (st_q)
            S_IDLE:        if (launch) st_d = S_IFEN;
            S_IFEN:        st_d = S_RSTALL;
            S_RSTALL:      st_d = S_HDIV_LD;
            S_HDIV_LD:     st_d = S_HDIV_EN;
            S_HDIV_EN:     st_d = S_HDIV_REL;
            S_HDIV_REL:    st_d = S_POR_HOLD;
            S_POR_HOLD:    if (expired) st_d = S_PHYCLK_WAIT;
            S_PHYCLK_WAIT: if (expired) st_d = S_TEST_PULSE;
            S_TEST_PULSE:  if (expired) st_d = S_TEST_GAP;
            S_TEST_GAP:    if (expired) st_d = S_FSDIV_REL;
            S_FSDIV_REL:   st_d = S_FSDIV_EN;
            S_FSDIV_EN:    if (expired) st_d = S_PORT_REL;
            S_PORT_REL:    if (expired) st_d = S_HOST_REL;
            S_HOST_REL:    st_d = S_TUNE;
            S_TUNE:        if (tune_last) st_d = S_READY;
            S_READY:       st_d = S_READY;
            default:       st_d = S_IDLE;
         endcase
      end
   end

   assign restart = (st_d != st_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= S_IDLE;
      else        st_q <= st_d;
   end

   // Port walk for the tune writes; a single port needs no index register.
   generate
      if (N_PORTS > 1) begin : g_multi_port
         logic [PORT_W-1:0] idx_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  idx_q <= '0;
            else if (st_q == S_TUNE && st_d == S_TUNE)   idx_q <= idx_q + PORT_W'(1);
            else                                         idx_q <= '0;
         end
         assign tune_idx  = idx_q;
         assign tune_last = (idx_q == PORT_W'(N_PORTS - 1));
      end else begin : g_single_port
         assign tune_idx  = '0;
         assign tune_last = 1'b1;
      end
   endgenerate

   // Controls accumulate as the step order advances.
   assign if_clk_en      = (st_q != S_IDLE);
   assign phy_por        = (st_q >= S_RSTALL) && (st_q <= S_POR_HOLD);
   assign hdiv_sel       = (st_q >= S_HDIV_LD) ? HDIV_VAL : '0;
   assign hdiv_en        = (st_q >= S_HDIV_EN);
   assign hdiv_rst_n     = (st_q >= S_HDIV_REL);
   assign phy_test_rst   = (st_q == S_TEST_PULSE);
   assign fsdiv_rst_n    = (st_q >= S_FSDIV_REL);
   assign fsdiv_en       = (st_q >= S_FSDIV_EN);
   assign phy_port_rst_n = (st_q >= S_PORT_REL);
   assign host_rst_n     = (st_q >= S_HOST_REL);
   assign tune_we        = (st_q == S_TUNE);
   assign tune_port      = tune_we ? tune_idx : '0;
   assign tune_val       = tune_we ? TUNE_VAL : 4'd0;
   assign busy           = (st_q != S_IDLE) && (st_q != S_READY);
   assign ready          = (st_q == S_READY);

   AST_HOST_AFTER_POR: assert property (@(posedge clk) disable iff (!rst_n)
      host_rst_n |-> !phy_por);                                          // R5
   AST_TEST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      phy_test_rst |-> (!phy_por && hdiv_rst_n && !fsdiv_rst_n));        // R4
   AST_RDY_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready && busy));                                                 // R13
   AST_TUNE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (tune_we && tune_port != '0) |-> $past(tune_we));                  // R6
   AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(tune_we && tune_last));                     // R6
   AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> (!if_clk_en && !busy && !ready));                         // R11
   AST_HSEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      hdiv_en |-> $stable(hdiv_sel));                                    // R7

endmodule

// File: tb/tb_usbclk_seq.sv
module tb_usbclk_seq;

   localparam longint unsigned B_HZ = 64'd1_000_000_000;
   localparam int B_MS  = 50;
   localparam int B_US  = 7;
   localparam int B_W64 = 64;
   localparam int NSW   = 14;
   localparam longint unsigned R_HZ = 64'd33_333_333;

   function automatic int bcyc(input longint unsigned hz, input longint unsigned ns);
      longint unsigned c;
      c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
      if (c == 0) c = 1;
      return int'(c);
   endfunction

   function automatic logic [3:0] bdiv(input longint unsigned hz);
      int q;
      q = int'(hz / 64'd130_000_000);
      if (q == 0) return 4'd1;
      if (q <= 4) return 4'(q);
      if (q == 5) return 4'd4;
      if (q <= 7) return 4'd6;
      if (q <= 11) return 4'd8;
      return 4'd12;
   endfunction

   localparam int B_ATE = bcyc(B_HZ, 10);
   localparam int B_GAP = bcyc(B_HZ, 20);
   localparam logic [3:0] B_DIV = bdiv(B_HZ);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_req = 1'b0;
   logic stop_req = 1'b0;
   logic aux_start = 1'b0;
   always #4 clk = ~clk;

   logic if_clk_en, phy_por, phy_port_rst_n, host_rst_n, hdiv_en, hdiv_rst_n;
   logic fsdiv_en, fsdiv_rst_n, phy_test_rst, tune_we, busy, ready;
   logic [3:0] hdiv_sel, tune_val;
   logic [0:0] tune_port;

   usbclk_seq #(.IO_CLK_HZ(B_HZ), .PHYCLK_WAIT_CYC(B_MS), .PORT_WAIT_CYC(B_US)) dut (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
      .if_clk_en(if_clk_en), .phy_por(phy_por), .phy_port_rst_n(phy_port_rst_n),
      .host_rst_n(host_rst_n), .hdiv_en(hdiv_en), .hdiv_rst_n(hdiv_rst_n),
      .fsdiv_en(fsdiv_en), .fsdiv_rst_n(fsdiv_rst_n), .hdiv_sel(hdiv_sel),
      .phy_test_rst(phy_test_rst), .tune_we(tune_we), .tune_port(tune_port),
      .tune_val(tune_val), .busy(busy), .ready(ready));

   logic [3:0] sw_sel [NSW];
   logic       sw_rdy [NSW];

   for (genvar k = 0; k < NSW; k++) begin : g_sw
      localparam longint unsigned HZ = 64'd130_000_000 * k + 64'd65_000_000;
      logic a0, a1, a2, a3, a4, a5, a6, a7, a8, a9, a10, rd;
      logic [3:0] sel, tv;
      logic [0:0] tp;
      usbclk_seq #(.IO_CLK_HZ(HZ), .PHYCLK_WAIT_CYC(3), .PORT_WAIT_CYC(2)) u_sw (
         .clk(clk), .rst_n(rst_n), .start_req(aux_start), .stop_req(1'b0),
         .if_clk_en(a0), .phy_por(a1), .phy_port_rst_n(a2), .host_rst_n(a3),
         .hdiv_en(a4), .hdiv_rst_n(a5), .fsdiv_en(a6), .fsdiv_rst_n(a7),
         .hdiv_sel(sel), .phy_test_rst(a8), .tune_we(a9), .tune_port(tp),
         .tune_val(tv), .busy(a10), .ready(rd));
      assign sw_sel[k] = sel;
      assign sw_rdy[k] = rd;
   end

   logic r0, r1, r2, r3, r4, r5, r6, r7, r8, r9, r10, rnd_rdy;
   logic [3:0] rnd_sel, rnd_tv;
   logic [0:0] rnd_tp;
   usbclk_seq #(.IO_CLK_HZ(R_HZ)) u_rnd (
      .clk(clk), .rst_n(rst_n), .start_req(aux_start), .stop_req(1'b0),
      .if_clk_en(r0), .phy_por(r1), .phy_port_rst_n(r2), .host_rst_n(r3),
      .hdiv_en(r4), .hdiv_rst_n(r5), .fsdiv_en(r6), .fsdiv_rst_n(r7),
      .hdiv_sel(rnd_sel), .phy_test_rst(r8), .tune_we(r9), .tune_port(rnd_tp),
      .tune_val(rnd_tv), .busy(r10), .ready(rnd_rdy));

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // Step durations of the main instance, index 0 = interface clock enable.
   function automatic int dur(input int s);
      case (s)
         5:  return B_W64;
         6:  return B_MS;
         7:  return B_ATE;
         8:  return B_GAP;
         10: return B_W64;
         11: return B_US;
         13: return 2;
         default: return 1;
      endcase
   endfunction

   function automatic int t_ready();
      int acc = 0;
      for (int s = 0; s < 14; s++) acc += dur(s);
      return acc;
   endfunction

   function automatic int stage_of(input int t);
      int acc = 0;
      if (t < 0) return -1;
      for (int s = 0; s < 14; s++) begin
         if (t < acc + dur(s)) return s;
         acc += dur(s);
      end
      return 14;
   endfunction

   function automatic int sub_of(input int t);
      int acc = 0;
      for (int s = 0; s < 14; s++) begin
         if (t < acc + dur(s)) return t - acc;
         acc += dur(s);
      end
      return 0;
   endfunction

   // Bit order: if_en por port_n host_n hen hrst_n fsen fsrst_n sel[4] test we port val[4] busy ready
   function automatic logic [20:0] exp_vec(input int t);
      int s, u;
      logic tw;
      s = stage_of(t);
      u = (s == 13) ? sub_of(t) : 0;
      if (s < 0) return '0;
      tw = (s == 13);
      return {1'b1, (s >= 1 && s <= 5), (s >= 11), (s >= 12), (s >= 3), (s >= 4),
              (s >= 10), (s >= 9), ((s >= 2) ? B_DIV : 4'd0), (s == 7), tw,
              1'(u), (tw ? 4'd15 : 4'd0), (s <= 13), (s == 14)};
   endfunction

   function automatic string tag_of(input int t);
      int s;
      s = stage_of(t);
      if (s < 0)   return "R1";
      if (s <= 4)  return "R2";
      if (s <= 6)  return "R3";
      if (s <= 8)  return "R4";
      if (s <= 12) return "R5";
      return "R6";
   endfunction

   logic [20:0] act;
   assign act = {if_clk_en, phy_por, phy_port_rst_n, host_rst_n, hdiv_en, hdiv_rst_n,
                 fsdiv_en, fsdiv_rst_n, hdiv_sel, phy_test_rst, tune_we, tune_port,
                 tune_val, busy, ready};

   task automatic chk(input logic [31:0] a, input logic [31:0] e, input string tag);
      n_chk++;
      if (a !== e) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, a, e, $time);
      end
   endtask

   task automatic chk_t(input int t, input string tag);
      chk(32'(act), 32'(exp_vec(t)), tag);
   endtask

   task automatic pulse_start();
      start_req = 1'b1; @(negedge clk); start_req = 1'b0;
   endtask

   task automatic pulse_stop();
      stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
   endtask

   // Checks every cycle of a bring-up; extra start at t == xs (R9).
   task automatic run_full(input int xs);
      for (int t = 0; t <= t_ready() + 3; t++) begin
         chk_t(t, (t == xs + 1) ? "R9" : tag_of(t));
         start_req = (t == xs);
         @(negedge clk);
      end
      start_req = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int tr;
      @(negedge clk); @(negedge clk);
      chk_t(-1, "R1");                     // R1 values during reset
      rst_n = 1'b1;
      @(negedge clk);
      chk_t(-1, "R1");

      // R2..R6 full sequence, R9 extra start while busy, R13 busy/ready
      pulse_start();
      run_full(30);                        // count now 2
      // R10: stop with count 2 -> 1, nothing changes
      pulse_stop();
      for (int i = 0; i < 3; i++) begin chk_t(t_ready(), "R10"); @(negedge clk); end
      // R9: start while ready does not rerun
      pulse_start();
      for (int i = 0; i < 5; i++) begin chk_t(t_ready(), "R9"); @(negedge clk); end
      pulse_stop();
      chk_t(t_ready(), "R10");
      pulse_stop();
      chk_t(-1, "R10");                    // count 0: all off next cycle
      // R12: stop at zero ignored
      pulse_stop();
      chk_t(-1, "R12");
      pulse_start();
      run_full(-10);
      pulse_stop();
      chk_t(-1, "R12");
      // R11: abort during wait
      pulse_start();
      repeat (100) @(negedge clk);
      chk_t(100, "R11");
      chk(32'(busy), 32'd1, "R13");
      pulse_stop();
      chk_t(-1, "R11");
      // R11: count 2 -> 1 keeps running, then abort
      pulse_start();
      pulse_start();
      chk_t(1, "R11");
      pulse_stop();
      chk_t(2, "R11");
      pulse_stop();
      chk_t(-1, "R11");
      pulse_start();
      chk_t(0, "R11");                     // restarts from first step
      pulse_stop();
      chk_t(-1, "R11");

      // R8 rounding instance and R7 quotient sweep
      tr = 5 + 64 + bcyc(R_HZ, 1_000_000) + bcyc(R_HZ, 10) + bcyc(R_HZ, 20)
           + 1 + 64 + bcyc(R_HZ, 1000) + 1 + 2;
      aux_start = 1'b1; @(negedge clk); aux_start = 1'b0;
      repeat (tr - 1) @(negedge clk);
      chk(32'(rnd_rdy), 32'd0, "R8");
      @(negedge clk);
      chk(32'(rnd_rdy), 32'd1, "R8");
      chk(32'(rnd_sel), 32'(bdiv(R_HZ)), "R7");
      for (int k = 0; k < NSW; k++) begin
         chk(32'(sw_rdy[k]), 32'd1, "R7");
         chk(32'(sw_sel[k]), 32'(bdiv(64'd130_000_000 * k + 64'd65_000_000)), "R7");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule